// File: doc/BRIEF.md
# LIN Transceiver Mode and Wake-up Controller

This block is the digital control core of a single-wire LIN bus transceiver. It runs one of three operating modes: standby, normal and sleep. The mode follows a synchronized enable input and the sampled level of the bus. In normal mode the block passes transmit data to the bus driver and receive data back to the protocol controller. Outside normal mode it holds the driver recessive. A thermal-shutdown input also forces the driver recessive in any mode.

The block has a regulator-inhibit output. This output is driven high in standby and normal. In sleep it is released, so that an external voltage regulator can switch off. A dominant bus level wakes the block from sleep only if it lasts for a programmable number of clock cycles. Shorter disturbances restart the filter and leave the mode unchanged. Raising the enable input also leaves sleep, and goes straight to normal mode. Slope shaping, receiver thresholds and current limiting belong to the analog part and appear here only as digital signals.

Top module: `lin_mode_ctrl`

## Requirements
- R1: After reset the block is in standby: `inh_oe_o` = 1 and `drv_dom_o` = 0.
- R2: In standby, a high `en_i` enters normal mode at the third rising clock edge after `en_i` rises, because of the two synchronizer stages. It does not enter normal mode at the second edge.
- R3: In normal mode, a low `en_i` enters sleep at the third rising edge after it falls. In sleep `inh_oe_o` = 0, which releases the inhibit output.
- R4: In sleep with `en_i` low, let the synchronized bus be dominant (`bus_i` = 0) for WAKE_CYCLES consecutive samples. The last of those samples moves the block to standby, and `inh_oe_o` goes to 1. With the bus driven low, this is the (WAKE_CYCLES+2)-th rising edge.
- R5: A dominant level shorter than WAKE_CYCLES synchronized samples causes no mode change. The wake filter restarts whenever the bus returns to recessive.
- R6: In sleep, a high `en_i` enters normal mode directly, with no bus wake-up, at the third rising edge after it rises.
- R7: In standby, `en_i` low keeps the block in standby with `inh_oe_o` = 1.
- R8: `drv_dom_o` is 0 (recessive) in standby and in sleep, and whenever `tsd_i` = 1.
- R9: `rxd_o` equals `bus_i` in standby and normal. It is held at 1 in sleep.
- R10: The encoding is as follows. `txd_i` = 0 requests dominant, `bus_i` = 0 means the bus is dominant, and `drv_dom_o` = 1 pulls the bus dominant. In normal mode with `tsd_i` = 0, `drv_dom_o` = NOT `txd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| en_i | input | 1 | Mode enable, asynchronous; low selects low-power operation |
| bus_i | input | 1 | Sampled bus level from the receiver comparator; 0 = dominant |
| txd_i | input | 1 | Transmit data; 0 = dominant |
| tsd_i | input | 1 | Thermal shutdown flag; 1 = overtemperature |
| rxd_o | output | 1 | Receive data; 0 while the bus is dominant |
| drv_dom_o | output | 1 | Bus driver control; 1 = pull bus dominant |
| inh_oe_o | output | 1 | Inhibit pad drive enable; 1 = drive high, 0 = released |

## Verification
The assertions check the mode sequencing on every cycle. Normal mode is entered only from a synchronized enable. A low enable in normal mode always leads to sleep. Standby holds while enable stays low. Sleep is kept while the bus is recessive or the filter count is short. A completed filter count always leads to standby. The bench scenarios are needed for the exact latencies seen at the ports: the third-edge mode change after an enable edge and the (WAKE_CYCLES+2)-th-edge wake. The scenarios also show that the filter restarts after repeated short pulses, and they cover the combinational gating of the driver and receive path under random transmit, thermal and bus activity.

// File: rtl/lin_mode_ctrl.sv
module lin_mode_ctrl #(
  parameter int WAKE_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bus_i,
  input  logic txd_i,
  input  logic tsd_i,
  output logic rxd_o,
  output logic drv_dom_o,
  output logic inh_oe_o
);

  localparam int CNT_W = $clog2(WAKE_CYCLES + 1);
  localparam logic [CNT_W-1:0] WAKE_LAST = CNT_W'(WAKE_CYCLES - 1);

  typedef enum logic [1:0] {ST_SBY = 2'd0, ST_NRM = 2'd1, ST_SLP = 2'd2} mode_t;

  mode_t state, state_nx;
  logic en_s1, en_s2, bus_s1, bus_s2;
  logic [CNT_W-1:0] wake_cnt;
  logic wake_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_s1  <= 1'b0;
      en_s2  <= 1'b0;
      bus_s1 <= 1'b1;
      bus_s2 <= 1'b1;
    end else begin
      en_s1  <= en_i;
      en_s2  <= en_s1;
      bus_s1 <= bus_i;
      bus_s2 <= bus_s1;
    end
  end

  assign wake_hit = (state == ST_SLP) && !bus_s2 && (wake_cnt == WAKE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                     wake_cnt <= '0;
    else if (state != ST_SLP || bus_s2 || en_s2)    wake_cnt <= '0;
    else if (!wake_hit)                             wake_cnt <= wake_cnt + 1'b1;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_SBY:  state_nx = en_s2 ? ST_NRM : ST_SBY;
      ST_NRM:  state_nx = en_s2 ? ST_NRM : ST_SLP;
      ST_SLP:  state_nx = en_s2 ? ST_NRM : (wake_hit ? ST_SBY : ST_SLP);
      default: state_nx = ST_SBY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SBY;
    else        state <= state_nx;
  end

  assign inh_oe_o  = (state != ST_SLP);
  assign drv_dom_o = (state == ST_NRM) && !tsd_i && !txd_i;
  assign rxd_o     = (state == ST_SLP) | bus_i;

  p_normal_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_NRM && !en_s2) |=> (state != ST_NRM));

  p_normal_exit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_NRM && !en_s2) |=> (state == ST_SLP && !inh_oe_o));

  p_wake_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && !en_s2 && !bus_s2 && wake_cnt == WAKE_LAST) |=> (state == ST_SBY && inh_oe_o));

  p_stay_asleep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLP && !en_s2 && (bus_s2 || wake_cnt != WAKE_LAST)) |=> (state == ST_SLP));

  p_standby_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SBY && !en_s2) |=> (state == ST_SBY && inh_oe_o));

endmodule

// File: tb/lin_mode_ctrl_tb.sv
module lin_mode_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int W = 20;
  localparam logic [1:0] M_SBY = 2'd0, M_NRM = 2'd1, M_SLP = 2'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_i = 1'b0, bus_i = 1'b1, txd_i = 1'b1, tsd_i = 1'b0;
  logic rxd_o, drv_dom_o, inh_oe_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  lin_mode_ctrl #(.WAKE_CYCLES(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .bus_i(bus_i), .txd_i(txd_i),
    .tsd_i(tsd_i), .rxd_o(rxd_o), .drv_dom_o(drv_dom_o), .inh_oe_o(inh_oe_o));

  // Reference model built from the requirements
  logic [1:0] m_st;
  logic m_e1, m_e2, m_b1, m_b2;
  int m_run;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= M_SBY; m_e1 <= 1'b0; m_e2 <= 1'b0; m_b1 <= 1'b1; m_b2 <= 1'b1; m_run <= 0;
    end else begin
      m_e1 <= en_i; m_e2 <= m_e1; m_b1 <= bus_i; m_b2 <= m_b1;
      if (m_e2) begin
        m_st <= M_NRM; m_run <= 0;
      end else if (m_st == M_NRM) begin
        m_st <= M_SLP; m_run <= 0;
      end else if (m_st == M_SLP && !m_b2) begin
        if (m_run + 1 == W) begin m_st <= M_SBY; m_run <= 0; end
        else m_run <= m_run + 1;
      end else m_run <= 0;
    end
  end

  function automatic logic exp_drv(logic [1:0] st, logic t, logic th);
    return (st == M_NRM) && !th && !t;
  endfunction
  function automatic logic exp_rxd(logic [1:0] st, logic b);
    return (st == M_SLP) ? 1'b1 : b;
  endfunction
  function automatic logic exp_inh(logic [1:0] st);
    return st != M_SLP;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int run;
    void'($urandom(32'h5eed_1a2b));
    txd_i = 1'b0;
    #(CLK_P * 2 + 1);
    chk("R1 inh after reset", inh_oe_o, 1'b1);
    chk("R1/R8 drv after reset", drv_dom_o, 1'b0);
    @(negedge clk); rst_n = 1'b1; txd_i = 1'b1;
    edges(5);
    chk("R7 standby hold inh", inh_oe_o, 1'b1);
    txd_i = 1'b0; #1;
    chk("R8 standby drv recessive", drv_dom_o, 1'b0);
    bus_i = 1'b0; #1;
    chk("R9 standby rxd follows bus", rxd_o, 1'b0);
    bus_i = 1'b1;
    // R2 latency
    en_i = 1'b1;
    edges(2);
    chk("R2 not normal at edge 2", drv_dom_o, 1'b0);
    edges(1);
    chk("R2 normal at edge 3", drv_dom_o, 1'b1);
    txd_i = 1'b1; #1;
    chk("R10 txd high gives recessive", drv_dom_o, 1'b0);
    txd_i = 1'b0; tsd_i = 1'b1; #1;
    chk("R8 thermal forces recessive", drv_dom_o, 1'b0);
    tsd_i = 1'b0;
    // R3 to sleep
    en_i = 1'b0;
    edges(2);
    chk("R3 inh still driven at edge 2", inh_oe_o, 1'b1);
    edges(1);
    chk("R3 inh released in sleep", inh_oe_o, 1'b0);
    chk("R8 sleep drv recessive", drv_dom_o, 1'b0);
    // R5 short pulses
    for (int k = 0; k < 2; k++) begin
      bus_i = 1'b0; #1;
      chk("R9 rxd high in sleep", rxd_o, 1'b1);
      edges(W - 1);
      bus_i = 1'b1;
      edges(5);
      chk("R5 short pulse no wake", inh_oe_o, 1'b0);
    end
    // R4 long pulse
    bus_i = 1'b0;
    edges(W + 1);
    chk("R4 not awake before filter ends", inh_oe_o, 1'b0);
    edges(1);
    chk("R4 awake into standby", inh_oe_o, 1'b1);
    chk("R8 standby after wake drv", drv_dom_o, 1'b0);
    chk("R9 rxd follows bus after wake", rxd_o, 1'b0);
    bus_i = 1'b1;
    edges(4);
    chk("R7 standby stays with en low", inh_oe_o, 1'b1);
    // R6 direct exit from sleep
    en_i = 1'b1; edges(3);
    en_i = 1'b0; edges(3);
    chk("R3 back in sleep", inh_oe_o, 1'b0);
    en_i = 1'b1; edges(3);
    chk("R6 sleep to normal inh", inh_oe_o, 1'b1);
    chk("R6 sleep to normal drv", drv_dom_o, 1'b1);
    // Random phase against the model
    run = 0;
    for (int c = 0; c < 5000; c++) begin
      @(negedge clk);
      txd_i = 1'($urandom_range(0, 1));
      tsd_i = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 59) == 0) en_i = ~en_i;
      if (run == 0) begin
        bus_i = ~bus_i;
        run = $urandom_range(1, 2 * W);
      end
      run--;
      #1;
      chk("R8/R10 model drv", drv_dom_o, exp_drv(m_st, txd_i, tsd_i));
      chk("R9 model rxd", rxd_o, exp_rxd(m_st, bus_i));
      chk("R4/R5 model inh", inh_oe_o, exp_inh(m_st));
    end
    finish_run();
  end
endmodule